// File: doc/BRIEF.md
# Scanned Keypad Encoder with Key Queue

This block walks a switch matrix one row at a time, reads eight active-low return lines for the selected row, and turns each qualified key closure into an 8-bit code that a host pulls from an eight-entry queue. The row lines are either driven as a binary row number (encoded style, up to eight rows through an external decoder) or as four one-cold select lines (decoded style, four rows driven directly). A prescaler sets how many clocks each row stays selected. One clock-wide read strobe removes the oldest code, and an interrupt output stays high while any code is waiting.

A closure must be seen again on the next two visits to its row before it is accepted. Then it is queued exactly once for that press. Two acceptance policies exist: two-key lockout (the default after reset), where the first key to close owns the keypad until it is released, and N-key rollover, where every held key is debounced and queued on its own. A one-cycle configuration write selects the policy and the scan style and clears all debounce state.

Top module: `keypad_scan_encoder`

## Requirements
- R1: A return line that reads 0 while its row is selected counts as a closed key at that row and column. The row holds its select for TICK_DIV clocks, and the return lines are sampled once per row visit.
- R2: In encoded style, which is the reset style or is selected by a configuration write with cfg_decoded=0, scan_lines carries {1'b0, row} and the row steps 0,1,...,7,0 in order.
- R3: In decoded style (cfg_decoded=1), exactly one of scan_lines[3:0] is low: bit k is low while row k is selected. Only rows 0 to 3 are visited, and the codes carry that row number.
- R4: A key is accepted only when it is read closed on three successive visits to its row, which is the first sighting plus two full scan cycles. A press seen on two or fewer successive visits queues nothing.
- R5: A key code is {ctrl, shift, row[2:0], col[2:0]}, with ctrl in bit 7 and shift in bit 6. Both modifier levels are taken at the visit that accepts the key.
- R6: A held key is queued once. It is queued again only after it has been read open and then debounced anew.
- R7: The queue holds eight codes in arrival order. key_data shows the oldest code, and a pop pulse removes it.
- R8: irq is 1 exactly while the queue holds at least one code.
- R9: With two-key lockout, the reset policy (cfg_rollover=0), the first closed key seen owns the keypad. Other keys are ignored until the owner is read open. Within one row the lowest column wins.
- R10: With N-key rollover (cfg_rollover=1), every held key is debounced and queued. Keys accepted in the same scan cycle are queued in row order, then column order.
- R11: After reset: lockout policy, encoded style at row 0 (scan_lines=0), empty queue, irq=0, and both error flags at 0.
- R12: A code accepted while the queue is full and no pop is in that cycle is dropped, and overrun becomes 1 and stays 1 until reset.
- R13: A pop while the queue is empty changes nothing in the queue and sets underrun, which stays 1 until reset.
- R14: A pop and an accepted code in the same cycle on a full queue both take effect: the oldest code leaves, the new code enters at the tail, and overrun stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ret_n | input | COLS | Return lines, active low |
| shift_key | input | 1 | Shift modifier level |
| ctrl_key | input | 1 | Control modifier level |
| cfg_we | input | 1 | Configuration write strobe; also clears debounce state |
| cfg_rollover | input | 1 | 1 selects N-key rollover, 0 two-key lockout |
| cfg_decoded | input | 1 | 1 selects decoded row lines, 0 encoded |
| pop | input | 1 | Removes the oldest queued code |
| scan_lines | output | 4 | Row select lines |
| key_data | output | 8 | Oldest queued key code |
| irq | output | 1 | High while the queue is not empty |
| overrun | output | 1 | Sticky: a code was dropped on a full queue |
| underrun | output | 1 | Sticky: a pop found the queue empty |

## Verification
The two functions that can meet in one clock are the acceptance of a debounced key, which writes the queue, and the host pop, which reads it. The case that matters is a full queue. Nine keys are held from reset in rollover mode, so eight codes fill the queue during the third scan and the ninth key's acceptance edge can be found from the prescaler period and the row and column walk. The bench raises pop for exactly that edge. It then requires overrun to stay 0 and the drained codes to be the seven remaining first-row keys followed by the ninth key. The same key set without the pop must instead set overrun and lose the ninth key.

// File: rtl/kp_pkg.sv
package kp_pkg;

    // Field widths fixed by the key code layout
    localparam int ROW_W  = 3;
    localparam int COL_W  = 3;
    localparam int CODE_W = 8;
    localparam int SCAN_W = 4;
    localparam int DEC_ROWS = 4;

    typedef struct packed {
        logic             ctrl;
        logic             shift;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } key_code_t;

    typedef enum logic {
        POL_LOCKOUT  = 1'b0,
        POL_ROLLOVER = 1'b1
    } key_policy_e;

    typedef enum logic {
        SCAN_ENCODED = 1'b0,
        SCAN_DECODED = 1'b1
    } scan_style_e;

    function automatic key_code_t make_code(input logic ctrl, input logic shift,
                                            input logic [ROW_W-1:0] row,
                                            input logic [COL_W-1:0] col);
        key_code_t c;
        c.ctrl  = ctrl;
        c.shift = shift;
        c.row   = row;
        c.col   = col;
        return c;
    endfunction

    function automatic logic [SCAN_W-1:0] row_lines(input scan_style_e style,
                                                    input logic [ROW_W-1:0] row);
        logic [SCAN_W-1:0] v;
        if (style == SCAN_DECODED)
            v = ~(SCAN_W'(1) << row[1:0]);
        else
            v = SCAN_W'(row);
        return v;
    endfunction

endpackage

// File: rtl/kp_scan_timer.sv
module kp_scan_timer
    import kp_pkg::*;
#(
    parameter int TICK_DIV = 16,
    parameter int ROWS     = 8,
    parameter int COLS     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  scan_style_e       style,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              eval,
    output logic              snap,
    output logic [SCAN_W-1:0] scan_lines
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [ROW_W-1:0] LAST_ENC = ROW_W'(ROWS - 1);
    localparam logic [ROW_W-1:0] LAST_DEC = ROW_W'(DEC_ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic [PRE_W-1:0] pre;
    logic             tick;
    logic [ROW_W-1:0] last_row;

    assign tick     = (pre == PRE_LAST);
    assign snap     = tick && !eval;
    assign last_row = (style == SCAN_DECODED) ? LAST_DEC : LAST_ENC;

    // Free-running prescaler: one tick per row slot
    always_ff @(posedge clk) begin
        if (rst)
            pre <= '0;
        else if (tick)
            pre <= '0;
        else
            pre <= pre + 1'b1;
    end

    // Column walk after each snapshot, row step at its end
    always_ff @(posedge clk) begin
        if (rst) begin
            eval <= 1'b0;
            col  <= '0;
            row  <= '0;
        end else if (snap) begin
            eval <= 1'b1;
            col  <= '0;
        end else if (eval) begin
            if (col == LAST_COL) begin
                eval <= 1'b0;
                col  <= '0;
                row  <= (row >= last_row) ? '0 : ROW_W'(row + 1'b1);
            end else begin
                col <= col + 1'b1;
            end
        end else if (row > last_row) begin
            row <= '0;
        end
    end

    assign scan_lines = row_lines(style, row);

    AST_DEC_ONECOLD: assert property (@(posedge clk) disable iff (rst)
        (style == SCAN_DECODED && row <= LAST_DEC) |-> ($countones(~scan_lines) == 1)); // R3

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (row != $past(row)) |-> (row == ROW_W'($past(row) + 1'b1) || row == '0)); // R2

endmodule

// File: rtl/kp_key_tracker.sv
module kp_key_tracker
    import kp_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int COLS      = 8,
    parameter int DEB_SCANS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  key_policy_e      policy,
    input  logic             snap,
    input  logic             eval,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [COLS-1:0]  ret_n,
    input  logic             shift_key,
    input  logic             ctrl_key,
    output logic             push,
    output key_code_t        code
);
    localparam int NKEYS = ROWS * COLS;
    localparam int IDX_W = $clog2(NKEYS);
    localparam int CNT_W = $clog2(DEB_SCANS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_SCANS);

    logic [CNT_W-1:0] kcnt  [NKEYS];
    logic             kdone [NKEYS];
    logic             lock_v;
    logic [IDX_W-1:0] lock_idx;
    logic [COLS-1:0]  ret_q;
    logic             shift_q;
    logic             ctrl_q;

    logic [IDX_W-1:0] cur;
    logic             closed;
    logic             owner;
    logic             elig;
    logic [CNT_W-1:0] cnt_cur;
    logic             done_cur;
    logic [CNT_W-1:0] cnt_nxt;
    logic             done_nxt;

    // Row snapshot taken at each prescaler tick
    always_ff @(posedge clk) begin
        if (rst) begin
            ret_q   <= '1;
            shift_q <= 1'b0;
            ctrl_q  <= 1'b0;
        end else if (snap) begin
            ret_q   <= ret_n;
            shift_q <= shift_key;
            ctrl_q  <= ctrl_key;
        end
    end

    assign cur      = IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);
    assign closed   = !ret_q[col];
    assign cnt_cur  = kcnt[cur];
    assign done_cur = kdone[cur];
    assign owner    = lock_v && (lock_idx == cur);

    always_comb begin
        if (policy == POL_ROLLOVER)
            elig = 1'b1;
        else
            elig = owner || (!lock_v && closed);
    end

    assign push = eval && elig && closed && (cnt_cur == CNT_MAX) && !done_cur;

    always_comb begin
        if (closed) begin
            cnt_nxt  = (cnt_cur == CNT_MAX) ? CNT_MAX : cnt_cur + 1'b1;
            done_nxt = done_cur || push;
        end else begin
            cnt_nxt  = '0;
            done_nxt = 1'b0;
        end
    end

    // Per-key debounce counters, one key updated per clock
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < NKEYS; i++) begin
                kcnt[i]  <= '0;
                kdone[i] <= 1'b0;
            end
        end else if (eval && elig) begin
            kcnt[cur]  <= cnt_nxt;
            kdone[cur] <= done_nxt;
        end
    end

    // Lockout owner
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lock_v   <= 1'b0;
            lock_idx <= '0;
        end else if (eval && policy == POL_LOCKOUT) begin
            if (!lock_v && closed) begin
                lock_v   <= 1'b1;
                lock_idx <= cur;
            end else if (owner && !closed) begin
                lock_v <= 1'b0;
            end
        end
    end

    assign code = make_code(ctrl_q, shift_q, row, col);

    logic [NKEYS-1:0] active;
    always_comb begin
        for (int i = 0; i < NKEYS; i++)
            active[i] = (kcnt[i] != '0) || kdone[i];
    end

    AST_LOCK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (policy == POL_LOCKOUT) |-> ($countones(active) <= 1)); // R9

    AST_PUSH_IN_WALK: assert property (@(posedge clk) disable iff (rst)
        push |-> (eval && !snap)); // R1

endmodule

// File: rtl/kp_key_fifo.sv
module kp_key_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         overrun,
    output logic         underrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          full;
    logic          pop_ok;
    logic          push_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
            if (push && !push_ok)
                overrun <= 1'b1;
            if (pop && empty)
                underrun <= 1'b1;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R7

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count) && overrun)); // R12

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> underrun); // R13

    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (push && pop && full) |=> (count == FULL_CNT && overrun == $past(overrun))); // R14

endmodule

// File: rtl/keypad_scan_encoder.sv
module keypad_scan_encoder
    import kp_pkg::*;
#(
    parameter int TICK_DIV   = 16,
    parameter int ROWS       = 8,
    parameter int COLS       = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int DEB_SCANS  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COLS-1:0]   ret_n,
    input  logic              shift_key,
    input  logic              ctrl_key,
    input  logic              cfg_we,
    input  logic              cfg_rollover,
    input  logic              cfg_decoded,
    input  logic              pop,
    output logic [SCAN_W-1:0] scan_lines,
    output logic [CODE_W-1:0] key_data,
    output logic              irq,
    output logic              overrun,
    output logic              underrun
);
    key_policy_e      policy;
    scan_style_e      style;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic             eval;
    logic             snap;
    logic             push;
    key_code_t        code;
    logic             empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            policy <= POL_LOCKOUT;
            style  <= SCAN_ENCODED;
        end else if (cfg_we) begin
            policy <= key_policy_e'(cfg_rollover);
            style  <= scan_style_e'(cfg_decoded);
        end
    end

    kp_scan_timer #(
        .TICK_DIV (TICK_DIV),
        .ROWS     (ROWS),
        .COLS     (COLS)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .style      (style),
        .row        (row),
        .col        (col),
        .eval       (eval),
        .snap       (snap),
        .scan_lines (scan_lines)
    );

    kp_key_tracker #(
        .ROWS      (ROWS),
        .COLS      (COLS),
        .DEB_SCANS (DEB_SCANS)
    ) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_we),
        .policy    (policy),
        .snap      (snap),
        .eval      (eval),
        .row       (row),
        .col       (col),
        .ret_n     (ret_n),
        .shift_key (shift_key),
        .ctrl_key  (ctrl_key),
        .push      (push),
        .code      (code)
    );

    kp_key_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (CODE_W)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .din      (code),
        .pop      (pop),
        .dout     (key_data),
        .empty    (empty),
        .overrun  (overrun),
        .underrun (underrun)
    );

    assign irq = !empty;

    AST_IRQ_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> irq); // R8

endmodule

// File: tb/tb_keypad_scan_encoder.sv
`timescale 1ns/1ps
module tb_keypad_scan_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] ret_n;
    logic       shift_key = 1'b0;
    logic       ctrl_key = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_rollover = 1'b0;
    logic       cfg_decoded = 1'b0;
    logic       pop = 1'b0;
    logic [3:0] scan_lines;
    logic [7:0] key_data;
    logic       irq;
    logic       overrun;
    logic       underrun;

    logic [7:0] keys [8];
    logic       tb_dec = 1'b0;
    int         cyc = 0;
    int         nchk = 0;
    int         nbad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    keypad_scan_encoder dut (
        .clk(clk), .rst(rst), .ret_n(ret_n), .shift_key(shift_key), .ctrl_key(ctrl_key),
        .cfg_we(cfg_we), .cfg_rollover(cfg_rollover), .cfg_decoded(cfg_decoded), .pop(pop),
        .scan_lines(scan_lines), .key_data(key_data), .irq(irq),
        .overrun(overrun), .underrun(underrun)
    );

    // Key matrix model: selected row pulls pressed columns low
    always_comb begin
        ret_n = 8'hFF;
        if (tb_dec) begin
            case (scan_lines)
                4'b1110: ret_n = ~keys[0];
                4'b1101: ret_n = ~keys[1];
                4'b1011: ret_n = ~keys[2];
                4'b0111: ret_n = ~keys[3];
                default: ret_n = 8'hFF;
            endcase
        end else begin
            ret_n = ~keys[scan_lines[2:0]];
        end
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic [7:0] kc(int r, int c, bit sh, bit ct);
        return {ct, sh, 3'(r), 3'(c)};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_keys();
        for (int i = 0; i < 8; i++) keys[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pop = 1'b0;
        cfg_we = 1'b0;
        tb_dec = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_mode(bit roll, bit dec);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_rollover = roll;
        cfg_decoded = dec;
        tb_dec = dec;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pop_code(output logic [7:0] d);
        @(negedge clk);
        d = key_data;
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        logic [3:0] prev;
        logic [3:0] seen;
        int         badv;

        clr_keys();
        do_reset();

        // Reset state
        @(negedge clk);
        chk(irq == 1'b0, "R11 irq", irq, 0);
        chk(overrun == 1'b0, "R11 overrun", overrun, 0);
        chk(underrun == 1'b0, "R11 underrun", underrun, 0);
        chk(scan_lines == 4'h0, "R11 scan row0", scan_lines, 0);

        // Encoded row stepping
        prev = scan_lines;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (scan_lines != prev) begin
                chk(scan_lines == {1'b0, 3'(prev[2:0] + 3'd1)}, "R2 row step",
                    scan_lines, {1'b0, 3'(prev[2:0] + 3'd1)});
                prev = scan_lines;
            end
        end

        // Exhaustive single-key sweep, lockout, modifiers varied
        for (int k = 0; k < 64; k++) begin
            shift_key = k[0];
            ctrl_key  = k[1];
            keys[k / 8][k % 8] = 1'b1;
            wait_cyc(512);
            chk(irq == 1'b1, "R8 irq on queued key", irq, 1);
            pop_code(d);
            chk(d == kc(k / 8, k % 8, k[0], k[1]), "R5 R1 key code", d, kc(k / 8, k % 8, k[0], k[1]));
            chk(irq == 1'b0, "R6 single queue while held", irq, 0);
            clr_keys();
            wait_cyc(256);
        end
        shift_key = 1'b0;
        ctrl_key  = 1'b0;

        // Short press is rejected
        do_reset();
        keys[3][2] = 1'b1;
        wait_cyc(250);
        clr_keys();
        wait_cyc(600);
        chk(irq == 1'b0, "R4 short press ignored", irq, 0);

        // Re-queue after release
        keys[5][6] = 1'b1;
        wait_cyc(512);
        pop_code(d);
        chk(d == kc(5, 6, 0, 0), "R6 first press", d, kc(5, 6, 0, 0));
        clr_keys();
        wait_cyc(256);
        keys[5][6] = 1'b1;
        wait_cyc(512);
        chk(irq == 1'b1, "R6 second press queued", irq, 1);
        pop_code(d);
        chk(d == kc(5, 6, 0, 0), "R6 second press code", d, kc(5, 6, 0, 0));
        clr_keys();
        wait_cyc(256);

        // Two-key lockout
        keys[2][5] = 1'b1;
        keys[4][1] = 1'b1;
        do_reset();
        wait_cyc(600);
        pop_code(d);
        chk(d == kc(2, 5, 0, 0), "R9 first key wins", d, kc(2, 5, 0, 0));
        chk(irq == 1'b0, "R9 second key locked out", irq, 0);
        keys[2][5] = 1'b0;
        wait_cyc(700);
        pop_code(d);
        chk(d == kc(4, 1, 0, 0), "R9 key after owner release", d, kc(4, 1, 0, 0));
        chk(irq == 1'b0, "R9 one code", irq, 0);
        clr_keys();
        wait_cyc(256);
        @(negedge clk);
        keys[6] = 8'b0000_1001;
        wait_cyc(600);
        pop_code(d);
        chk(d == kc(6, 0, 0, 0), "R9 lowest column in row", d, kc(6, 0, 0, 0));
        chk(irq == 1'b0, "R9 same-row second ignored", irq, 0);
        clr_keys();

        // N-key rollover ordering
        keys[1][2] = 1'b1;
        keys[3][7] = 1'b1;
        keys[5][0] = 1'b1;
        do_reset();
        set_mode(1'b1, 1'b0);
        wait_cyc(700);
        pop_code(d);
        chk(d == kc(1, 2, 0, 0), "R10 code 1", d, kc(1, 2, 0, 0));
        pop_code(d);
        chk(d == kc(3, 7, 0, 0), "R10 code 2", d, kc(3, 7, 0, 0));
        pop_code(d);
        chk(d == kc(5, 0, 0, 0), "R10 code 3", d, kc(5, 0, 0, 0));
        chk(irq == 1'b0, "R10 queue drained", irq, 0);
        clr_keys();

        // Overrun and underrun
        keys[0] = 8'hFF;
        keys[1][3] = 1'b1;
        do_reset();
        set_mode(1'b1, 1'b0);
        wait_cyc(700);
        chk(overrun == 1'b1, "R12 overrun set", overrun, 1);
        for (int c = 0; c < 8; c++) begin
            pop_code(d);
            chk(d == kc(0, c, 0, 0), "R7 R12 kept code", d, kc(0, c, 0, 0));
        end
        chk(irq == 1'b0, "R12 ninth code dropped", irq, 0);
        chk(underrun == 1'b0, "R13 no underrun yet", underrun, 0);
        pop_code(d);
        chk(underrun == 1'b1, "R13 underrun set", underrun, 1);
        chk(irq == 1'b0, "R13 queue still empty", irq, 0);
        chk(overrun == 1'b1, "R12 overrun sticky", overrun, 1);

        // Push and pop in the same cycle on a full queue
        do_reset();
        set_mode(1'b1, 1'b0);
        while (cyc != 291) @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        chk(overrun == 1'b0, "R14 no overrun", overrun, 0);
        for (int c = 1; c < 8; c++) begin
            pop_code(d);
            chk(d == kc(0, c, 0, 0), "R14 order", d, kc(0, c, 0, 0));
        end
        pop_code(d);
        chk(d == kc(1, 3, 0, 0), "R14 coincident code at tail", d, kc(1, 3, 0, 0));
        chk(irq == 1'b0, "R14 drained", irq, 0);
        chk(overrun == 1'b0, "R14 overrun clear", overrun, 0);
        clr_keys();

        // Decoded scan lines
        do_reset();
        set_mode(1'b0, 1'b1);
        seen = 4'h0;
        badv = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            case (scan_lines)
                4'b1110: seen[0] = 1'b1;
                4'b1101: seen[1] = 1'b1;
                4'b1011: seen[2] = 1'b1;
                4'b0111: seen[3] = 1'b1;
                default: badv++;
            endcase
        end
        chk(badv == 0, "R3 one line low", badv, 0);
        chk(seen == 4'hF, "R3 all four rows", seen, 4'hF);
        shift_key = 1'b1;
        keys[2][4] = 1'b1;
        wait_cyc(400);
        pop_code(d);
        chk(d == kc(2, 4, 1, 0), "R3 decoded key code", d, kc(2, 4, 1, 0));
        clr_keys();
        shift_key = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule